// File: doc/BRIEF.md
# Regular Square-Multiply Modular Exponentiator

This block raises a base to an exponent modulo a modulus, all unsigned and of parameterizable width. It walks the exponent one bit per iteration, starting just below the top bit and moving down to bit 0. Each iteration squares the running value and also multiplies that square by the base. Both products are formed on every bit, and the exponent bit only decides which one is kept. The sequence of operations therefore never depends on the key.

Products are formed by an internal shift-and-add modular multiplier. It reduces after each step and takes the same number of cycles for every operand. The block is idle until `start` is seen. It then captures its operands and runs for a fixed number of cycles, which depends only on the two width parameters. It marks the finished result with a one-cycle `done` pulse. The caller must supply a modulus of at least 2 and a base smaller than the modulus. The result is undefined otherwise.

Top module: `rsqm_exp_top`

## Requirements
- R1: After a run, `result` equals base^e mod modulus, where e is the exponent with bit EXP_WIDTH-1 forced to 1. This holds for any modulus in [2, 2^WIDTH-1] and any base smaller than the modulus, and the result is always below the modulus.
- R2: The value of exponent bit EXP_WIDTH-1 has no effect. Two runs whose operands differ only in that bit give the same `result`.
- R3: `done` is high for exactly one cycle per run.
- R4: `done` rises exactly LAT = (EXP_WIDTH-1)*2*(WIDTH+2)+1 rising clock edges after the edge that accepts `start`, whatever the operand values.
- R5: `result` changes only in the cycle in which `done` is high. It holds its value from then until the next run completes.
- R6: A `start` raised while a run is in progress is ignored. It alters neither that run's `result` nor its latency.
- R7: While `rstN` is low, and after it is released, `done` is 0 and `result` is 0 until the first run completes.
- R8: Edge operands are handled correctly. A base of 0 gives 0, a base of 1 gives 1, and a modulus of 2 or of 2^WIDTH-1 works. This includes an exponent of all ones and one whose only set bit is the top one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| base | input | WIDTH | Base, must be less than modulus |
| exponent | input | EXP_WIDTH | Exponent; top bit treated as 1 |
| modulus | input | WIDTH | Modulus, at least 2 |
| result | output | WIDTH | Exponentiation result, held until the next run completes |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
The bench targets the top exponent bit with paired runs that differ only in that bit. A design that scanned it would return a different power. It drives bases of 0, 1 and modulus-1, and moduli of 2 and the widest value, where a multiplier that missed a final subtraction would leave a result at or above the modulus. It raises `start` in the middle of a run with other operands. A control path that restarted would then give a wrong result or a shorter or longer latency. Every run's cycle count is compared with the fixed figure, which exposes any key-dependent skipping of the multiply.

// File: rtl/rsqm_exp_pkg.sv
package rsqm_exp_pkg;
  // Strobes issued by the control to the datapath, one per cycle at most.
  typedef struct packed {
    logic load;    // capture operands, seed accumulator with base
    logic sqGo;    // launch accumulator squaring
    logic capSq;   // store square as candidate y0
    logic mulGo;   // launch y0 * base
    logic pick;    // keep y0 or y1 according to exponent bit
    logic finish;  // publish accumulator, pulse done
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQ_GO,
    ST_SQ_WAIT,
    ST_MU_GO,
    ST_MU_WAIT,
    ST_FINISH
  } ctrlState_t;
endpackage

// File: rtl/rsqm_modmul.sv
module rsqm_modmul #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modIn,
  output logic [WIDTH-1:0] product,
  output logic             mulDone
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] aQ, bQ, mQ, accQ;
  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic [WIDTH:0]   dbl, dblRed, sum, sumRed;

  // One MSB-first step: double, reduce, conditionally add a, reduce.
  always_comb begin
    dbl    = {accQ, 1'b0};
    dblRed = (dbl >= {1'b0, mQ}) ? dbl - {1'b0, mQ} : dbl;
    sum    = dblRed + (bQ[WIDTH-1] ? {1'b0, aQ} : '0);
    sumRed = (sum >= {1'b0, mQ}) ? sum - {1'b0, mQ} : sum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ      <= '0;
      bQ      <= '0;
      mQ      <= '0;
      accQ    <= '0;
      cntQ    <= '0;
      busyQ   <= 1'b0;
      mulDone <= 1'b0;
    end else begin
      mulDone <= 1'b0;
      if (start) begin
        aQ    <= opA;
        bQ    <= opB;
        mQ    <= modIn;
        accQ  <= '0;
        cntQ  <= CNT_W'(WIDTH);
        busyQ <= 1'b1;
      end else if (busyQ) begin
        accQ <= sumRed[WIDTH-1:0];
        bQ   <= bQ << 1;
        cntQ <= cntQ - 1'b1;
        if (cntQ == CNT_W'(1)) begin
          busyQ   <= 1'b0;
          mulDone <= 1'b1;
        end
      end
    end
  end

  assign product = accQ;
endmodule

// File: rtl/rsqm_exp_ctrl.sv
module rsqm_exp_ctrl
  import rsqm_exp_pkg::*;
#(
  parameter int EXP_WIDTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         mulDone,
  output ctrlStrobes_t strobes,
  output logic         busy
);
  localparam int BIT_CNT_W = $clog2(EXP_WIDTH);

  ctrlState_t           stateQ, stateD;
  logic [BIT_CNT_W-1:0] bitCntQ;
  logic                 lastBit;

  assign lastBit = (bitCntQ == BIT_CNT_W'(1));

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        stateD       = ST_SQ_GO;
      end
      ST_SQ_GO: begin
        strobes.sqGo = 1'b1;
        stateD       = ST_SQ_WAIT;
      end
      ST_SQ_WAIT: if (mulDone) begin
        strobes.capSq = 1'b1;
        stateD        = ST_MU_GO;
      end
      ST_MU_GO: begin
        strobes.mulGo = 1'b1;
        stateD        = ST_MU_WAIT;
      end
      ST_MU_WAIT: if (mulDone) begin
        strobes.pick = 1'b1;
        stateD       = lastBit ? ST_FINISH : ST_SQ_GO;
      end
      ST_FINISH: begin
        strobes.finish = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      bitCntQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strobes.load)      bitCntQ <= BIT_CNT_W'(EXP_WIDTH - 1);
      else if (strobes.pick) bitCntQ <= bitCntQ - 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/rsqm_exp_dp.sv
module rsqm_exp_dp
  import rsqm_exp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int EXP_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [WIDTH-1:0]     base,
  input  logic [EXP_WIDTH-1:0] exponent,
  input  logic [WIDTH-1:0]     modulus,
  output logic                 mulDone,
  output logic [WIDTH-1:0]     result,
  output logic                 done
);
  logic [WIDTH-1:0]     baseQ, modQ, accQ, y0Q, product;
  logic [EXP_WIDTH-1:0] expShiftQ;
  logic [WIDTH-1:0]     mulA, mulB;
  logic                 mulStart;

  // Both launches share the single multiplier; operands chosen by strobe.
  assign mulStart = strobes.sqGo | strobes.mulGo;
  assign mulA     = strobes.sqGo ? accQ : y0Q;
  assign mulB     = strobes.sqGo ? accQ : baseQ;

  rsqm_modmul #(.WIDTH(WIDTH)) mulI (
    .clk     (clk),
    .rstN    (rstN),
    .start   (mulStart),
    .opA     (mulA),
    .opB     (mulB),
    .modIn   (modQ),
    .product (product),
    .mulDone (mulDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      modQ      <= '0;
      accQ      <= '0;
      y0Q       <= '0;
      expShiftQ <= '0;
      result    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        baseQ     <= base;
        modQ      <= modulus;
        accQ      <= base;
        expShiftQ <= exponent << 1;  // top bit implied 1, consumed here
      end
      if (strobes.capSq) y0Q <= product;
      if (strobes.pick) begin
        accQ      <= expShiftQ[EXP_WIDTH-1] ? product : y0Q;
        expShiftQ <= expShiftQ << 1;
      end
      if (strobes.finish) begin
        result <= accQ;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsqm_exp_top.sv
module rsqm_exp_top
  import rsqm_exp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int EXP_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WIDTH-1:0]     base,
  input  logic [EXP_WIDTH-1:0] exponent,
  input  logic [WIDTH-1:0]     modulus,
  output logic [WIDTH-1:0]     result,
  output logic                 done
);
  ctrlStrobes_t strobes;
  logic         mulDone;
  logic         busy;

  rsqm_exp_ctrl #(.EXP_WIDTH(EXP_WIDTH)) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mulDone (mulDone),
    .strobes (strobes),
    .busy    (busy)
  );

  rsqm_exp_dp #(.WIDTH(WIDTH), .EXP_WIDTH(EXP_WIDTH)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .base     (base),
    .exponent (exponent),
    .modulus  (modulus),
    .mulDone  (mulDone),
    .result   (result),
    .done     (done)
  );
endmodule

// File: rtl/rsqm_exp_checker.sv
module rsqm_exp_checker #(
  parameter int WIDTH     = 16,
  parameter int EXP_WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic [WIDTH-1:0] modQ,
  input logic [WIDTH-1:0] result,
  input logic             done
);
  localparam int LAT = (EXP_WIDTH - 1) * 2 * (WIDTH + 2) + 1;

  logic [31:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else                     runCnt <= runCnt + 1;
  end

  // R1: published result is reduced
  p_result_reduced_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < modQ));
  // R3: single-cycle done
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: fixed latency from accepted start
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == 32'(LAT)));
  // R5: result only moves together with done
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);
  // R6: start during a run does not end it
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done));
  // R7: reset state
  always_comb begin
    if (!rstN) begin
      a_reset_done_r7: assert (!done);
    end
  end
endmodule

bind rsqm_exp_top rsqm_exp_checker #(.WIDTH(WIDTH), .EXP_WIDTH(EXP_WIDTH)) chkI (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .modQ   (dpI.modQ),
  .result (result),
  .done   (done)
);

// File: tb/rsqm_exp_top_tb_top.sv
module rsqm_exp_top_tb_top;
  localparam int WIDTH     = 16;
  localparam int EXP_WIDTH = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = (EXP_WIDTH - 1) * 2 * (WIDTH + 2) + 1;
  localparam int WATCHDOG = 150000;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic [WIDTH-1:0]     base = '0;
  logic [EXP_WIDTH-1:0] exponent = '0;
  logic [WIDTH-1:0]     modulus = '0;
  logic [WIDTH-1:0]     result;
  logic                 done;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h5eed1234;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsqm_exp_top #(.WIDTH(WIDTH), .EXP_WIDTH(EXP_WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .base(base),
    .exponent(exponent), .modulus(modulus), .result(result), .done(done)
  );

  function automatic longint unsigned refExp(longint unsigned b, longint unsigned e,
                                             longint unsigned m);
    longint unsigned r = 1;
    longint unsigned eff = e | (64'd1 << (EXP_WIDTH - 1));
    for (int i = EXP_WIDTH - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if (eff[i]) r = (r * b) % m;
    end
    return r;
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one exponentiation; optionally pokes start mid-run with other operands.
  task automatic runOne(input logic [WIDTH-1:0] b, input logic [EXP_WIDTH-1:0] e,
                        input logic [WIDTH-1:0] m, input bit poke,
                        output logic [WIDTH-1:0] res);
    int edges;
    @(negedge clk);
    base = b; exponent = e; modulus = m; start = 1'b1;
    @(posedge clk);
    edges = 0;
    @(negedge clk);
    start = 1'b0;
    base = ~b; exponent = ~e; modulus = m ^ 16'h0f0f;
    while (!done && edges < 2 * LAT) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (poke && edges == 40) start = 1'b1;
      if (poke && edges == 42) start = 1'b0;
    end
    start = 1'b0;
    res = result;
    if (poke) check("R6 latency with mid-run start", edges, LAT);
    else      check("R4 latency", edges, LAT);
    check("R1 result", res, refExp(b, e, m));
    check("R1 result below modulus", res < m, 1);
    @(negedge clk);
    check("R3 done pulse width", done, 0);
    repeat (3) @(negedge clk);
    check("R5 result held", result, res);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] r1, r2;
    logic [WIDTH-1:0] m;
    logic [EXP_WIDTH-1:0] e;
    repeat (3) @(negedge clk);
    check("R7 reset done", done, 0);
    check("R7 reset result", result, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 idle done after reset", done, 0);
    check("R7 idle result after reset", result, 0);

    // R8 corner operands
    runOne(16'd0, 16'h1234, 16'd977, 1'b0, r1);
    check("R8 base zero", r1, 0);
    runOne(16'd1, 16'hffff, 16'd977, 1'b0, r1);
    check("R8 base one", r1, 1);
    runOne(16'd976, 16'hffff, 16'd977, 1'b0, r1);
    runOne(16'd1, 16'h8000, 16'd2, 1'b0, r1);
    runOne(16'd0, 16'h0003, 16'd2, 1'b0, r1);
    runOne(16'hfffe, 16'hffff, 16'hffff, 1'b0, r1);
    runOne(16'h1234, 16'h8000, 16'hffff, 1'b0, r1);
    runOne(16'd3, 16'h8003, 16'd65521, 1'b0, r1);

    // R2 top exponent bit ignored
    runOne(16'd12345, 16'h0a5c, 16'd40009, 1'b0, r1);
    runOne(16'd12345, 16'h8a5c, 16'd40009, 1'b0, r2);
    check("R2 top bit ignored", r1, r2);

    // R6 start during a run
    runOne(16'd777, 16'h5a5a, 16'd50021, 1'b1, r1);

    // Constrained random
    void'($urandom(seed));
    for (int i = 0; i < 40; i++) begin
      m = 16'($urandom_range(65535, 2));
      e = 16'($urandom());
      runOne(16'($urandom() % m), e, m, (i % 10) == 5, r1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule